// File: doc/BRIEF.md
# Code Memory Access Guard

This block sits between the code ROM array and its two readers: an external programmer (device programming and verify), and the CPU's table-lookup reads of code space. It holds one byte of security settings. Each cycle it decides whether a requested read may reach the array. A blocked read returns all ones and raises a violation flag. Programmer reads of the code array leave the chip scrambled when encryption is on. The block also answers identification reads with fixed manufacturer and device bytes. The security byte is one-way. A normal write can only clear bits, and only a whole-chip erase sets them again.

A CPU read carries a tag that says whether the instruction doing the read was fetched from internal or from external program space. Code addresses below the size of the internal array are internal targets. Higher addresses belong to external memory, so the block only flags them for the bus. The programmer and the CPU share one array port, and the programmer has priority. All read responses are registered and appear one cycle after the request.

Top module: `code_guard`

## Requirements
- R1: After reset the security byte is FFh, no read response or violation is pending, and `oscFullGain` is 1.
- R2: Programmer setting-space reads return a byte one cycle after the request, selected by the low two address bits: 0 gives DAh, 1 gives E0h, 2 gives the security byte, and 3 gives FFh. Reads of addresses 0, 1 and 3 are never blocked.
- R3: A programmer write to setting address 2 stores (old AND written value) with bits 6:3 forced to 1, so no written value turns a 0 bit back to 1. Only a `chipErase` pulse restores FFh.
- R4: While security bit 0 is 0 (locked), programmer reads of the code array and of setting address 2 return FFh and assert `violation`.
- R5: While security bit 1 is 0, a CPU read of an internal address (below 2^ROM_AW) with `cpuFromExt`=1 returns FFh and asserts `violation`. The same read with `cpuFromExt`=0 returns the array byte.
- R6: While security bit 1 is 1, CPU reads of internal addresses return the array byte whatever `cpuFromExt` is.
- R7: While security bit 2 is 0, an unlocked programmer code read returns array byte XOR key, where key = {addr[3:0], ~addr[3:0]} XOR KEY_SEED (default A5h). While bit 2 is 1, the byte is returned unchanged.
- R8: CPU reads of internal code are never scrambled.
- R9: A CPU read of an address at or above 2^ROM_AW sets `cpuExtSel` with `cpuRdata`=FFh and never raises `violation`.
- R10: `oscFullGain` always equals security bit 7.
- R11: A CPU request in a cycle where `pgmValid` is high gets no response.
- R12: `violation` is high exactly in the cycles where a blocked read's response is presented, and that response is FFh.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| pgmValid | input | 1 | Programmer request |
| pgmWrite | input | 1 | 1 = write, 0 = read |
| pgmSetSpace | input | 1 | 1 = setting space, 0 = code array |
| pgmAddr | input | ROM_AW | Programmer address |
| pgmWdata | input | 8 | Programmer write data |
| chipErase | input | 1 | Whole-chip erase pulse |
| cpuValid | input | 1 | CPU code-space read |
| cpuFromExt | input | 1 | Reading instruction came from external program space |
| cpuAddr | input | CPU_AW | CPU code address |
| romRdata | input | 8 | Array data for `arrAddr`, same cycle |
| arrAddr | output | ROM_AW | Array read address |
| pgmRdValid | output | 1 | Programmer read response valid |
| pgmRdata | output | 8 | Programmer read data (bus side) |
| cpuRdValid | output | 1 | CPU read response valid |
| cpuRdata | output | 8 | CPU read data |
| cpuExtSel | output | 1 | Response belongs to external memory |
| violation | output | 1 | Blocked read in this response |
| oscFullGain | output | 1 | Oscillator gain select |

## Verification
Assertions check on every cycle that the security byte never gains a 1 except through erase, that its reserved bits stay set, that a locked code read is always blocked, that programmer priority holds, and that any violation comes with an FFh response. Only the bench scenarios can show the actual data values. These are the scrambled bytes and their keys, the identification bytes, the exact decision for each combination of inhibit bit and fetch origin, and how erase and write interact across a long random sequence.

// File: rtl/code_guard_pkg.sv
package code_guard_pkg;
  localparam int SecLock = 0;
  localparam int SecInhibit = 1;
  localparam int SecEncrypt = 2;
  localparam int SecOsc = 7;
  localparam logic [7:0] RsvMask = 8'h78;
  localparam logic [7:0] CompanyId = 8'hDA;
  localparam logic [7:0] DeviceId = 8'hE0;
  localparam logic [1:0] SecAddr = 2'd2;

  typedef struct packed {
    logic pgmRom;   // allowed programmer code read
    logic pgmSet;   // allowed programmer setting read
    logic pgmBlk;   // blocked programmer read
    logic secWr;    // security byte write
    logic erase;    // whole-chip erase
    logic cpuInt;   // allowed CPU internal read
    logic cpuExt;   // CPU read of external space
    logic cpuBlk;   // blocked CPU read
  } strobes_t;
endpackage

// File: rtl/code_guard_ctrl.sv
module code_guard_ctrl
  import code_guard_pkg::*;
#(
  parameter int ROM_AW = 13,
  parameter int CPU_AW = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              pgmValid,
  input  logic              pgmWrite,
  input  logic              pgmSetSpace,
  input  logic [1:0]        pgmSubAddr,
  input  logic              chipErase,
  input  logic              cpuValid,
  input  logic              cpuFromExt,
  input  logic [CPU_AW-1:0] cpuAddr,
  input  logic [7:0]        secBits,
  output strobes_t          st
);
  localparam int HiW = CPU_AW - ROM_AW;

  logic lockOn, inhibitOn, pgmRd, cpuGo, cpuInternal, secTarget;

  always_comb begin
    lockOn      = ~secBits[SecLock];
    inhibitOn   = ~secBits[SecInhibit];
    pgmRd       = pgmValid & ~pgmWrite;
    cpuGo       = cpuValid & ~pgmValid;
    cpuInternal = (cpuAddr[CPU_AW-1:ROM_AW] == {HiW{1'b0}});
    secTarget   = pgmSetSpace & (pgmSubAddr == SecAddr);

    st.pgmRom = pgmRd & ~pgmSetSpace & ~lockOn;
    st.pgmSet = pgmRd & pgmSetSpace & ~(secTarget & lockOn);
    st.pgmBlk = pgmRd & lockOn & (~pgmSetSpace | secTarget);
    st.secWr  = pgmValid & pgmWrite & secTarget;
    st.erase  = chipErase;
    st.cpuExt = cpuGo & ~cpuInternal;
    st.cpuBlk = cpuGo & cpuInternal & cpuFromExt & inhibitOn;
    st.cpuInt = cpuGo & cpuInternal & ~(cpuFromExt & inhibitOn);
  end

  // R4: a locked code read by the programmer must be blocked
  p_lock_blocks_r4: assert property (@(posedge clk) disable iff (!rstN)
    (pgmValid && !pgmWrite && !pgmSetSpace && !secBits[SecLock]) |-> (st.pgmBlk && !st.pgmRom));

  // R11: programmer owns the array port
  p_pgm_priority_r11: assert property (@(posedge clk) disable iff (!rstN)
    pgmValid |-> !(st.cpuInt || st.cpuExt || st.cpuBlk));

  // R9: external-space reads never count as violations
  p_ext_no_block_r9: assert property (@(posedge clk) disable iff (!rstN)
    st.cpuExt |-> !st.cpuBlk);
endmodule

// File: rtl/code_guard_dpath.sv
module code_guard_dpath
  import code_guard_pkg::*;
#(
  parameter int ROM_AW = 13,
  parameter int CPU_AW = 16,
  parameter logic [7:0] KEY_SEED = 8'hA5
) (
  input  logic              clk,
  input  logic              rstN,
  input  strobes_t          st,
  input  logic              pgmValid,
  input  logic [ROM_AW-1:0] pgmAddr,
  input  logic [7:0]        pgmWdata,
  input  logic [CPU_AW-1:0] cpuAddr,
  input  logic [7:0]        romRdata,
  output logic [7:0]        secBits,
  output logic [ROM_AW-1:0] arrAddr,
  output logic              pgmRdValid,
  output logic [7:0]        pgmRdata,
  output logic              cpuRdValid,
  output logic [7:0]        cpuRdata,
  output logic              cpuExtSel,
  output logic              violation,
  output logic              oscFullGain
);
  logic [7:0] secReg, keyByte, romOut, setData, pgmNext, cpuNext;

  always_comb begin
    arrAddr = pgmValid ? pgmAddr : cpuAddr[ROM_AW-1:0];
    keyByte = {pgmAddr[3:0], ~pgmAddr[3:0]} ^ KEY_SEED;
    romOut  = secReg[SecEncrypt] ? romRdata : (romRdata ^ keyByte);
    unique case (pgmAddr[1:0])
      2'd0:    setData = CompanyId;
      2'd1:    setData = DeviceId;
      2'd2:    setData = secReg;
      default: setData = 8'hFF;
    endcase
    if (st.pgmBlk)      pgmNext = 8'hFF;
    else if (st.pgmRom) pgmNext = romOut;
    else                pgmNext = setData;
    cpuNext = st.cpuInt ? romRdata : 8'hFF;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      secReg     <= 8'hFF;
      pgmRdValid <= 1'b0;
      pgmRdata   <= 8'hFF;
      cpuRdValid <= 1'b0;
      cpuRdata   <= 8'hFF;
      cpuExtSel  <= 1'b0;
      violation  <= 1'b0;
    end else begin
      if (st.erase)      secReg <= 8'hFF;
      else if (st.secWr) secReg <= (secReg & pgmWdata) | RsvMask;
      pgmRdValid <= st.pgmRom | st.pgmSet | st.pgmBlk;
      pgmRdata   <= pgmNext;
      cpuRdValid <= st.cpuInt | st.cpuExt | st.cpuBlk;
      cpuRdata   <= cpuNext;
      cpuExtSel  <= st.cpuExt;
      violation  <= st.pgmBlk | st.cpuBlk;
    end
  end

  assign secBits     = secReg;
  assign oscFullGain = secReg[SecOsc];

  // R3: without erase no security bit may rise
  p_one_way_r3: assert property (@(posedge clk) disable iff (!rstN)
    !st.erase |=> ((secReg & ~$past(secReg)) == 8'h00));

  // R3: reserved bits always read as ones
  p_reserved_set_r3: assert property (@(posedge clk) disable iff (!rstN)
    (secReg & RsvMask) == RsvMask);

  // R12: a violation always comes with an all-ones response
  p_violation_ff_r12: assert property (@(posedge clk) disable iff (!rstN)
    violation |-> ((pgmRdValid && pgmRdata == 8'hFF) || (cpuRdValid && cpuRdata == 8'hFF)));
endmodule

// File: rtl/code_guard.sv
module code_guard
  import code_guard_pkg::*;
#(
  parameter int ROM_AW = 13,
  parameter int CPU_AW = 16,
  parameter logic [7:0] KEY_SEED = 8'hA5
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              pgmValid,
  input  logic              pgmWrite,
  input  logic              pgmSetSpace,
  input  logic [ROM_AW-1:0] pgmAddr,
  input  logic [7:0]        pgmWdata,
  input  logic              chipErase,
  input  logic              cpuValid,
  input  logic              cpuFromExt,
  input  logic [CPU_AW-1:0] cpuAddr,
  input  logic [7:0]        romRdata,
  output logic [ROM_AW-1:0] arrAddr,
  output logic              pgmRdValid,
  output logic [7:0]        pgmRdata,
  output logic              cpuRdValid,
  output logic [7:0]        cpuRdata,
  output logic              cpuExtSel,
  output logic              violation,
  output logic              oscFullGain
);
  strobes_t   st;
  logic [7:0] secBits;

  code_guard_ctrl #(.ROM_AW(ROM_AW), .CPU_AW(CPU_AW)) ctrl_i (
    .clk(clk), .rstN(rstN), .pgmValid(pgmValid), .pgmWrite(pgmWrite),
    .pgmSetSpace(pgmSetSpace), .pgmSubAddr(pgmAddr[1:0]), .chipErase(chipErase),
    .cpuValid(cpuValid), .cpuFromExt(cpuFromExt), .cpuAddr(cpuAddr),
    .secBits(secBits), .st(st)
  );

  code_guard_dpath #(.ROM_AW(ROM_AW), .CPU_AW(CPU_AW), .KEY_SEED(KEY_SEED)) dpath_i (
    .clk(clk), .rstN(rstN), .st(st), .pgmValid(pgmValid), .pgmAddr(pgmAddr),
    .pgmWdata(pgmWdata), .cpuAddr(cpuAddr), .romRdata(romRdata),
    .secBits(secBits), .arrAddr(arrAddr), .pgmRdValid(pgmRdValid),
    .pgmRdata(pgmRdata), .cpuRdValid(cpuRdValid), .cpuRdata(cpuRdata),
    .cpuExtSel(cpuExtSel), .violation(violation), .oscFullGain(oscFullGain)
  );
endmodule

// File: tb/code_guard_tb_top.sv
module code_guard_tb_top;
  localparam int ROM_AW = 13;
  localparam int CPU_AW = 16;

  logic clk = 1'b0, rstN = 1'b0;
  logic pgmValid = 0, pgmWrite = 0, pgmSetSpace = 0, chipErase = 0;
  logic cpuValid = 0, cpuFromExt = 0;
  logic [ROM_AW-1:0] pgmAddr = '0;
  logic [7:0] pgmWdata = '0;
  logic [CPU_AW-1:0] cpuAddr = '0;
  logic [7:0] romRdata;
  logic [ROM_AW-1:0] arrAddr;
  logic pgmRdValid, cpuRdValid, cpuExtSel, violation, oscFullGain;
  logic [7:0] pgmRdata, cpuRdata;

  int nChecks = 0, nFails = 0;
  logic [7:0] expSec = 8'hFF;
  bit done = 0;

  always #10 clk = ~clk;

  function automatic logic [7:0] romModel(logic [ROM_AW-1:0] a);
    return a[7:0] ^ {a[12:8], 3'b101};
  endfunction
  function automatic logic [7:0] keyOf(logic [ROM_AW-1:0] a);
    return {a[3:0], ~a[3:0]} ^ 8'hA5;
  endfunction

  assign romRdata = romModel(arrAddr);

  code_guard dut_i (.*);

  task automatic chk(string req, logic [15:0] act, logic [15:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic idle();
    pgmValid = 0; pgmWrite = 0; cpuValid = 0; chipErase = 0;
  endtask

  task automatic pgmRead(bit setSp, logic [ROM_AW-1:0] a);
    logic [7:0] e; bit blk;
    blk = !expSec[0] && (!setSp || a[1:0] == 2'd2);
    if (blk) e = 8'hFF;
    else if (!setSp) e = expSec[2] ? romModel(a) : romModel(a) ^ keyOf(a);
    else case (a[1:0])
      2'd0: e = 8'hDA; 2'd1: e = 8'hE0; 2'd2: e = expSec; default: e = 8'hFF;
    endcase
    @(negedge clk);
    pgmValid = 1; pgmWrite = 0; pgmSetSpace = setSp; pgmAddr = a;
    @(negedge clk);
    idle();
    chk(setSp ? "R2 setting read" : (blk ? "R4 locked read" : "R7 code read"),
        {7'd0, pgmRdValid, pgmRdata}, {7'd0, 1'b1, e});
    chk("R12 violation pgm", {15'd0, violation}, {15'd0, blk});
  endtask

  task automatic secWrite(logic [7:0] w);
    @(negedge clk);
    pgmValid = 1; pgmWrite = 1; pgmSetSpace = 1; pgmAddr = 13'd2; pgmWdata = w;
    @(negedge clk);
    idle();
    expSec = (expSec & w) | 8'h78;
    chk("R10 osc gain", {15'd0, oscFullGain}, {15'd0, expSec[7]});
  endtask

  task automatic erase();
    @(negedge clk); chipErase = 1;
    @(negedge clk); idle();
    expSec = 8'hFF;
  endtask

  task automatic cpuRead(logic [CPU_AW-1:0] a, bit fromExt);
    bit intl, blk; logic [7:0] e;
    intl = (a < 16'h2000);
    blk = intl && fromExt && !expSec[1];
    e = (intl && !blk) ? romModel(a[ROM_AW-1:0]) : 8'hFF;
    @(negedge clk);
    cpuValid = 1; cpuAddr = a; cpuFromExt = fromExt;
    @(negedge clk);
    idle();
    chk(blk ? "R5 inhibited read" : (intl ? "R6/R8 internal read" : "R9 external read"),
        {6'd0, cpuRdValid, cpuExtSel, cpuRdata}, {6'd0, 1'b1, !intl, e});
    chk("R12 violation cpu", {15'd0, violation}, {15'd0, blk});
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    if (!done) begin
      nChecks++; nFails++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5EC0DE));
    repeat (3) @(negedge clk);
    chk("R1 reset valid", {13'd0, pgmRdValid, cpuRdValid, violation}, 16'd0);
    rstN = 1;
    @(negedge clk);
    chk("R1 reset osc", {15'd0, oscFullGain}, 16'd1);
    pgmRead(1, 13'd2);               // R1 security byte FF
    pgmRead(1, 13'd0);               // R2 company id
    pgmRead(1, 13'd1);               // R2 device id
    pgmRead(1, 13'd3);               // R2 spare
    pgmRead(0, 13'h0123);            // R7 plain
    cpuRead(16'h0040, 1);            // R6 no restriction
    secWrite(8'hFB);                 // enable scrambling
    pgmRead(0, 13'h1ABC);            // R7 scrambled
    cpuRead(16'h1ABC, 0);            // R8 not scrambled
    secWrite(8'hFF);                 // R3 cannot undo
    pgmRead(1, 13'd2);
    secWrite(8'hFD);                 // inhibit
    cpuRead(16'h0100, 1);            // R5 blocked
    cpuRead(16'h0100, 0);            // R5 allowed from internal
    cpuRead(16'h2000, 1);            // R9 boundary
    cpuRead(16'hFFFF, 0);
    // R11 collision
    @(negedge clk);
    pgmValid = 1; pgmSetSpace = 1; pgmAddr = 13'd0; cpuValid = 1; cpuAddr = 16'h10;
    @(negedge clk); idle();
    chk("R11 cpu dropped", {14'd0, cpuRdValid, pgmRdValid}, 16'd1);
    secWrite(8'h7E);                 // lock, half gain
    pgmRead(0, 13'h0055);            // R4
    pgmRead(1, 13'd2);               // R4
    pgmRead(1, 13'd1);               // R2 id still readable
    erase();                         // R3 erase
    pgmRead(1, 13'd2);
    chk("R3/R10 erase osc", {15'd0, oscFullGain}, 16'd1);
    for (int i = 0; i < 400; i++) begin
      int unsigned k;
      k = $urandom % 20;
      if (k == 0) erase();
      else if (k < 4) secWrite(8'($urandom) | ((($urandom % 4) != 0) ? 8'h07 : 8'h00));
      else if (k < 9) pgmRead(0, ROM_AW'($urandom));
      else if (k < 12) pgmRead(1, ROM_AW'($urandom % 4));
      else cpuRead(CPU_AW'($urandom % 16'h4000), 1'($urandom));
    end
    done = 1;
    $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
    $finish;
  end
endmodule